// File: doc/BRIEF.md
# Power-Stage Fault Latch and Status Encoder

This block sits between the protection comparators of a two-channel power stage and the gate sequencers that drive its MOSFETs. It takes four synchronous fault flags: overcurrent, overtemperature error, overtemperature warning and gate-supply undervoltage. Error flags are captured in a sticky latch that asserts a kill line toward the gate sequencers. A three-bit status word reports the cause.

The status word holds two code bits and an active-low shutdown flag. If more than one error type is latched, the word shows a dedicated multiple-error code. The overtemperature warning never latches and never stops switching; it only changes the code bits while it lasts.

Each audio channel has its own active-low reset input. The latch is cleared only by a low-to-high transition on either reset, and only when no error flag is active. The block comes out of system reset in the latched state. While either channel reset is held low, the shutdown flag is released high so the controller upstream can see that a recovery is in progress.

Top module: `pwr_fault_ctl`

## Requirements
- R1: After the system reset `rst_n` is released, `gate_kill` is 1 and the status word {code_b0, code_b1, shut_n} is 000. This holds until a channel reset rises while no fault is present.
- R2: With both channel resets high, the status word shows exactly one latched error type as follows: overcurrent 100, overtemperature error 010, undervoltage 110. With nothing latched it shows 111, and with the warning active and nothing latched it shows 011. A latched error always takes precedence over the warning code.
- R3: The status word never takes the values 001 or 101, so `shut_n` = 1 always implies `code_b1` = 1.
- R4: An error flag that is high at one rising clock edge is latched even if it is only one cycle long. `gate_kill` = 1 and `shut_n` = 0 become visible after the (FLT_DELAY-1)-th following edge, which is after the second edge with the default FLT_DELAY = 2. Before that, the outputs are unchanged.
- R5: If two or more error types are latched, the status word is 000.
- R6: While either channel reset has been sampled low, `shut_n` is 1 and `code_b1` is 1. `code_b0` is 0 if the warning is active and 1 otherwise. `gate_kill` keeps its latched value.
- R7: A channel reset sampled low at one edge and high at the next clears every latched error and the power-up state at that second edge. This happens only when no error flag is high at the input or still in the delay pipeline. The outputs then read 111 (or 011 with the warning) and `gate_kill` = 0.
- R8: A channel reset rising edge that occurs while any error flag is still active, including a persisting undervoltage, leaves the latch and `gate_kill` set.
- R9: The overtemperature warning follows its input with the same FLT_DELAY latency as the errors. It never sets `gate_kill` and disappears once the input has been low through that latency.
- R10: The two channel resets act independently. A rising edge on either one alone is enough to clear the latch under the conditions of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| chan_a_rst_n | input | 1 | Active-low reset of the first audio channel |
| chan_b_rst_n | input | 1 | Active-low reset of the second audio channel |
| oc_flag | input | 1 | Overcurrent error flag |
| ot_err_flag | input | 1 | Overtemperature error flag |
| ot_warn_flag | input | 1 | Overtemperature warning flag (non-latching) |
| uv_flag | input | 1 | Gate-supply undervoltage flag |
| code_b0 | output | 1 | Status code bit 0 |
| code_b1 | output | 1 | Status code bit 1 |
| shut_n | output | 1 | Active-low shutdown indication |
| gate_kill | output | 1 | Forces all gate drives low when 1 |

## Verification
A latch bit that is stuck or lost changes the status word and `gate_kill` no later than the cycle after the fault's delay window. This makes it visible right after the latency checks of R4.

A clear that happens too early shows up at the first rising reset edge while a fault persists, because `gate_kill` drops there. A missed clear shows up as a kill that stays set after a clean reset pulse.

Errors in edge detection or in the hold register appear within one cycle of a reset transition, as a wrong shutdown level or a wrong code. Random mixes of faults and reset pulses, compared every cycle against a bench model, expose wrong priority between errors, the multiple-error code, and warning leakage into the kill line.

// File: rtl/pwr_fault_pkg.sv
package pwr_fault_pkg;

    typedef struct packed {
        logic oc;
        logic ot;
        logic uv;
    } err_vec_t;

    typedef struct packed {
        err_vec_t err;
        logic     warn;
    } flag_t;

    typedef struct packed {
        logic b0;
        logic b1;
        logic shut_n;
    } status_t;

    localparam status_t ST_MULTI  = '{b0: 1'b0, b1: 1'b0, shut_n: 1'b0};
    localparam status_t ST_OT_ERR = '{b0: 1'b0, b1: 1'b1, shut_n: 1'b0};
    localparam status_t ST_OT_WRN = '{b0: 1'b0, b1: 1'b1, shut_n: 1'b1};
    localparam status_t ST_OC_ERR = '{b0: 1'b1, b1: 1'b0, shut_n: 1'b0};
    localparam status_t ST_UV_ERR = '{b0: 1'b1, b1: 1'b1, shut_n: 1'b0};
    localparam status_t ST_NORMAL = '{b0: 1'b1, b1: 1'b1, shut_n: 1'b1};

    function automatic logic any_err(input err_vec_t e);
        return e.oc | e.ot | e.uv;
    endfunction

endpackage

// File: rtl/pwr_flag_delay.sv
module pwr_flag_delay
    import pwr_fault_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  flag_t flg_i,
    output flag_t dly_o,
    output logic  inflight_o
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dly_o      = flg_i;
            assign inflight_o = 1'b0;
        end else begin : g_pipe
            flag_t stg_d [DEPTH];
            flag_t stg_q [DEPTH];
            logic  busy_d;

            always_comb begin
                stg_d[0] = flg_i;
                for (int i = 1; i < DEPTH; i++) begin
                    stg_d[i] = stg_q[i-1];
                end
                busy_d = 1'b0;
                for (int i = 0; i < DEPTH; i++) begin
                    busy_d = busy_d | any_err(stg_q[i].err);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        stg_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        stg_q[i] <= stg_d[i];
                    end
                end
            end

            assign dly_o      = stg_q[DEPTH-1];
            assign inflight_o = busy_d;
        end
    endgenerate

endmodule

// File: rtl/pwr_fault_latch.sv
module pwr_fault_latch
    import pwr_fault_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  err_vec_t raw_err_i,
    input  flag_t    dly_i,
    input  logic     inflight_i,
    input  logic     chan_a_n_i,
    input  logic     chan_b_n_i,
    output err_vec_t lat_o,
    output logic     boot_o,
    output logic     warn_o,
    output logic     hold_o
);

    typedef struct packed {
        err_vec_t lat;
        logic     boot;
        logic     warn;
        logic     prev_a;
        logic     prev_b;
        logic     hold;
    } lstate_t;

    lstate_t st_d, st_q;
    logic    rise_d;
    logic    pend_d;

    always_comb begin
        rise_d = (!st_q.prev_a && chan_a_n_i) || (!st_q.prev_b && chan_b_n_i);
        pend_d = any_err(raw_err_i) | any_err(dly_i.err) | inflight_i;
        st_d   = st_q;
        if (rise_d && !pend_d) begin
            st_d.lat  = '0;
            st_d.boot = 1'b0;
        end
        st_d.lat    = st_d.lat | dly_i.err;
        st_d.warn   = dly_i.warn;
        st_d.prev_a = chan_a_n_i;
        st_d.prev_b = chan_b_n_i;
        st_d.hold   = !chan_a_n_i || !chan_b_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat    <= '0;
            st_q.boot   <= 1'b1;
            st_q.warn   <= 1'b0;
            st_q.prev_a <= 1'b1;
            st_q.prev_b <= 1'b1;
            st_q.hold   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o  = st_q.lat;
    assign boot_o = st_q.boot;
    assign warn_o = st_q.warn;
    assign hold_o = st_q.hold;

    // R4: a delayed error flag is captured at the next edge
    p_set_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_err(dly_i.err) |=> any_err(st_q.lat));

    // R8: active fault keeps the latched state through any reset edge
    p_hold_while_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_err(raw_err_i) && (any_err(st_q.lat) || st_q.boot))
        |=> (any_err(st_q.lat) || st_q.boot));

    // R7: the power-up hold leaves only on a channel reset rising edge
    p_clear_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.boot) |-> $past(rise_d));

endmodule

// File: rtl/pwr_status_enc.sv
module pwr_status_enc
    import pwr_fault_pkg::*;
(
    input  err_vec_t lat_i,
    input  logic     boot_i,
    input  logic     warn_i,
    input  logic     hold_i,
    output status_t  st_o,
    output logic     kill_o
);

    logic [1:0] n_err;

    always_comb begin
        n_err = 2'($countones(lat_i));
        if (hold_i) begin
            st_o = '{b0: !warn_i, b1: 1'b1, shut_n: 1'b1};
        end else if (boot_i || n_err > 2'd1) begin
            st_o = ST_MULTI;
        end else if (lat_i.oc) begin
            st_o = ST_OC_ERR;
        end else if (lat_i.ot) begin
            st_o = ST_OT_ERR;
        end else if (lat_i.uv) begin
            st_o = ST_UV_ERR;
        end else if (warn_i) begin
            st_o = ST_OT_WRN;
        end else begin
            st_o = ST_NORMAL;
        end
        kill_o = boot_i | any_err(lat_i);
    end

endmodule

// File: rtl/pwr_fault_ctl.sv
module pwr_fault_ctl
    import pwr_fault_pkg::*;
#(
    parameter int FLT_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_a_rst_n,
    input  logic chan_b_rst_n,
    input  logic oc_flag,
    input  logic ot_err_flag,
    input  logic ot_warn_flag,
    input  logic uv_flag,
    output logic code_b0,
    output logic code_b1,
    output logic shut_n,
    output logic gate_kill
);

    localparam int PIPE_DEPTH = (FLT_DELAY > 1) ? FLT_DELAY - 1 : 0;

    flag_t    raw_flg;
    flag_t    dly_flg;
    logic     inflight;
    err_vec_t lat;
    logic     boot;
    logic     warn;
    logic     hold;
    status_t  st;
    logic     kill;

    always_comb begin
        raw_flg.err.oc = oc_flag;
        raw_flg.err.ot = ot_err_flag;
        raw_flg.err.uv = uv_flag;
        raw_flg.warn   = ot_warn_flag;
    end

    pwr_flag_delay #(.DEPTH(PIPE_DEPTH)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .flg_i      (raw_flg),
        .dly_o      (dly_flg),
        .inflight_o (inflight)
    );

    pwr_fault_latch u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_err_i  (raw_flg.err),
        .dly_i      (dly_flg),
        .inflight_i (inflight),
        .chan_a_n_i (chan_a_rst_n),
        .chan_b_n_i (chan_b_rst_n),
        .lat_o      (lat),
        .boot_o     (boot),
        .warn_o     (warn),
        .hold_o     (hold)
    );

    pwr_status_enc u_enc (
        .lat_i  (lat),
        .boot_i (boot),
        .warn_i (warn),
        .hold_i (hold),
        .st_o   (st),
        .kill_o (kill)
    );

    assign code_b0   = st.b0;
    assign code_b1   = st.b1;
    assign shut_n    = st.shut_n;
    assign gate_kill = kill;

    // R3: codes 001 and 101 never appear
    p_no_invalid_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shut_n |-> code_b1);

    // R6: outside a channel reset, shutdown mirrors the kill line
    p_shut_tracks_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chan_a_rst_n) && $past(chan_b_rst_n)) |-> (shut_n == !gate_kill));

    // R6: inside a channel reset, shutdown is released
    p_release_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_a_rst_n || !chan_b_rst_n) |=> shut_n);

endmodule

// File: tb/pwr_fault_ctl_test.sv
`timescale 1ns/1ps
module pwr_fault_ctl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ca = 1'b1, cb = 1'b1;
    logic oc = 1'b0, ot = 1'b0, wr = 1'b0, uv = 1'b0;
    logic code_b0, code_b1, shut_n, gate_kill;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    pwr_fault_ctl #(.FLT_DELAY(2)) uut (
        .clk(clk), .rst_n(rst_n), .chan_a_rst_n(ca), .chan_b_rst_n(cb),
        .oc_flag(oc), .ot_err_flag(ot), .ot_warn_flag(wr), .uv_flag(uv),
        .code_b0(code_b0), .code_b1(code_b1), .shut_n(shut_n), .gate_kill(gate_kill)
    );

    // reference model, delay 2: one pipeline stage then the latch
    logic m_boot, m_oc, m_ot, m_uv, m_w, m_pa, m_pb, m_hold;
    logic p_oc, p_ot, p_uv, p_w;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_boot = 1; m_oc = 0; m_ot = 0; m_uv = 0; m_w = 0;
            m_pa = 1; m_pb = 1; m_hold = 0;
            p_oc = 0; p_ot = 0; p_uv = 0; p_w = 0;
        end else begin
            if (((!m_pa && ca) || (!m_pb && cb)) &&
                !(oc | ot | uv | p_oc | p_ot | p_uv)) begin
                m_boot = 0; m_oc = 0; m_ot = 0; m_uv = 0;
            end
            m_oc = m_oc | p_oc; m_ot = m_ot | p_ot; m_uv = m_uv | p_uv;
            m_w = p_w;
            p_oc = oc; p_ot = ot; p_uv = uv; p_w = wr;
            m_pa = ca; m_pb = cb; m_hold = !ca || !cb;
        end
    end

    function automatic logic [2:0] exp_status();
        int n = int'(m_oc) + int'(m_ot) + int'(m_uv);
        if (m_hold)               return {!m_w, 1'b1, 1'b1};
        if (m_boot || n > 1)      return 3'b000;
        if (m_oc)                 return 3'b100;
        if (m_ot)                 return 3'b010;
        if (m_uv)                 return 3'b110;
        if (m_w)                  return 3'b011;
        return 3'b111;
    endfunction

    function automatic logic exp_kill();
        return m_boot | m_oc | m_ot | m_uv;
    endfunction

    task automatic chk_lit(input string tag, input logic [2:0] es, input logic ek);
        n_cmp++;
        if ({code_b0, code_b1, shut_n} !== es || gate_kill !== ek) begin
            n_bad++;
            $display("FAIL %s: status=%b kill=%b expected status=%b kill=%b",
                     tag, {code_b0, code_b1, shut_n}, gate_kill, es, ek);
        end
    endtask

    task automatic chk_model(input string tag);
        chk_lit(tag, exp_status(), exp_kill());
        n_cmp++;
        if (shut_n && !code_b1) begin
            n_bad++;
            $display("FAIL R3: status=%b expected shut_n=1 only with code_b1=1",
                     {code_b0, code_b1, shut_n});
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5182));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk_lit("R1 power-up latched", 3'b000, 1'b1);
        tick();
        chk_lit("R1 stays latched", 3'b000, 1'b1);

        ca = 0; tick();
        chk_lit("R6 hold releases shutdown", 3'b111, 1'b1);
        ca = 1; tick();
        chk_lit("R7 rise clears power-up", 3'b111, 1'b0);

        oc = 1; tick();
        chk_lit("R4 not before latency", 3'b111, 1'b0);
        oc = 0; tick();
        chk_lit("R4 one-cycle overcurrent latched", 3'b100, 1'b1);
        ot = 1; tick();
        ot = 0; tick();
        chk_lit("R5 multiple errors", 3'b000, 1'b1);

        cb = 0; tick();
        chk_lit("R6 hold with errors", 3'b111, 1'b1);
        cb = 1; tick();
        chk_lit("R10 second channel clears", 3'b111, 1'b0);

        uv = 1; tick(); tick();
        chk_lit("R2 undervoltage code", 3'b110, 1'b1);
        ca = 0; tick();
        ca = 1; tick();
        chk_lit("R8 rise during undervoltage", 3'b110, 1'b1);
        uv = 0; tick(); tick();
        chk_lit("R8 still latched after release", 3'b110, 1'b1);
        ca = 0; tick();
        ca = 1; tick();
        chk_lit("R7 clear after fault gone", 3'b111, 1'b0);

        ot = 1; tick(); ot = 0; tick();
        chk_lit("R2 overtemperature error code", 3'b010, 1'b1);
        cb = 0; tick(); cb = 1; tick();
        chk_lit("R7 clear overtemperature", 3'b111, 1'b0);

        wr = 1; tick(); tick();
        chk_lit("R9 warning code no kill", 3'b011, 1'b0);
        cb = 0; tick();
        chk_lit("R6 hold with warning", 3'b011, 1'b0);
        cb = 1; tick();
        wr = 0; tick();
        chk_lit("R9 warning latency", 3'b011, 1'b0);
        tick();
        chk_lit("R9 warning gone", 3'b111, 1'b0);

        wr = 1; oc = 1; tick();
        oc = 0; tick();
        chk_lit("R9 error dominates warning", 3'b100, 1'b1);
        wr = 0; ca = 0; tick();
        ca = 1; tick();
        chk_lit("R7 clear after mixed", 3'b111, 1'b0);

        for (int k = 0; k < 4000; k++) begin
            oc = ($urandom % 60) == 0;
            ot = ($urandom % 80) == 0;
            uv = ($urandom % 3 == 0) ? uv ^ (($urandom % 30) == 0) : uv;
            if (($urandom % 20) == 0) wr = ~wr;
            ca = ca ? (($urandom % 25) != 0) : (($urandom % 3) == 0);
            cb = cb ? (($urandom % 25) != 0) : (($urandom % 3) == 0);
            tick();
            chk_model("R2");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule